// File: doc/BRIEF.md
# Card Command and Response Unit

This unit issues one command to a memory card and holds the card's reply for the host. The host loads a 32-bit argument and then writes a command word. The command word carries a 6-bit index, a response-expected bit, a long-response bit, an interrupt-mode bit, a pending bit and an enable bit. Writing the command word with enable set, and pending clear, starts a transaction. The unit offers the index and the argument on a valid/ready request port. It then collects the card's reply, which arrives as a byte stream that may have gaps and ends with a last marker or an error marker.

When the reply ends, the unit judges it against what the command asked for. A good reply is packed into four 32-bit response words, with the earliest byte in the most significant position. The unit then raises exactly one of three sticky outcome flags: command sent, response received or timeout. The host clears a flag by writing a one to its bit position. While a transaction is in flight the unit reports busy and ignores any command or argument writes.

Top module: `card_cmd_unit`

## Requirements
- R1: After reset the unit is idle, no request is offered, the command word, argument, all four response words and all flags read zero.
- R2: A command write made while idle, with bit 10 (enable) set and bit 9 (pending) clear, raises `req_valid` on the next cycle. `req_index` then equals bits 5:0 of the command and `req_arg` equals the stored argument. All three hold steady until `req_ready` is seen high.
- R3: A command write with bit 9 (pending) set issues no request. The word is stored with bit 10 read back as zero.
- R4: Bit 10 of the stored command reads one exactly while `busy` is high and clears when the reply ends. Command and argument writes made while busy are ignored.
- R5: Reply bytes are packed big-endian. Byte k of the reply goes to word k/4, bits 31-8*(k%4) down to 24-8*(k%4), so the first byte lands in bits 31:24 of word 0.
- R6: When a response is expected and not long, a 4-byte reply loads word 0, clears words 1 to 3 and sets status bit 6.
- R7: When a response is expected, a 16-byte reply loads all four words with bit 0 of word 3 forced to zero and sets status bit 6. The long bit (command bit 7) does not change this.
- R8: When a response is expected, a reply of 0 bytes, a reply of 4 bytes with bit 7 set, or a reply of any length other than 4 or 16 sets status bit 2 (timeout) and leaves the response words unchanged.
- R9: When no response is expected (command bit 6 clear), a reply ending without error sets status bit 7 whatever its length, and the response words stay unchanged.
- R10: A reply beat with `rsp_err` set ends the transaction with status bit 2 and leaves the response words unchanged.
- R11: Status bits 2, 6 and 7 are sticky. `flag_clr` clears the bits where it has ones. A flag being set in the same cycle wins over its clear. All other status bits read zero.
- R12: Command bit 8 (interrupt mode) is stored but has no effect on issuing or completing a command.
- R13: Reply beats that arrive while idle or while the request is still waiting for `req_ready` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_wr | input | 1 | Write `wdata` to the argument register |
| cmd_wr | input | 1 | Write `wdata[10:0]` to the command register |
| wdata | input | 32 | Host write data |
| flag_clr | input | 8 | Write-one-to-clear mask for the status byte |
| cmd_q | output | 11 | Stored command word |
| busy | output | 1 | Transaction in flight |
| st_flags | output | 8 | Status: bit 7 sent, bit 6 response end, bit 2 timeout |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| req_valid | output | 1 | Request offered to the card |
| req_ready | input | 1 | Card accepts the request |
| req_index | output | 6 | Command index to the card |
| req_arg | output | 32 | Command argument to the card |
| rsp_valid | input | 1 | Reply beat present |
| rsp_byte | input | 8 | Reply data byte |
| rsp_nodata | input | 1 | Beat carries no byte; only meaningful with `rsp_last` |
| rsp_last | input | 1 | Final beat of the reply |
| rsp_err | input | 1 | Card reports failure; ends the reply |

## Verification
The bench targets the length judgement. It sends a short reply to a long request, an empty reply, a 7-byte reply and a 16-byte reply to a short request. A design that decides from the long bit alone, or that commits bytes before the verdict, would set the wrong flag or corrupt the words kept from an earlier reply. It also ends the reply on a data-free terminator beat and on an error beat, to catch a byte counter that counts the wrong beats. It checks that bit 0 of the last long word is masked, so a design that keeps the card's bit is caught. It hits the unit with command and argument writes mid-transaction, stray reply beats while idle or waiting for a grant, and a clear that collides with a flag being set. Designs that latch late writes, act on stray beats or let the clear win all diverge from the reference model within a cycle.

// File: rtl/card_cmd_unit.sv
module card_cmd_unit #(
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arg_wr,
  input  logic             cmd_wr,
  input  logic [ARG_W-1:0] wdata,
  input  logic [7:0]       flag_clr,
  output logic [10:0]      cmd_q,
  output logic             busy,
  output logic [7:0]       st_flags,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [5:0]       req_index,
  output logic [ARG_W-1:0] req_arg,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_byte,
  input  logic             rsp_nodata,
  input  logic             rsp_last,
  input  logic             rsp_err
);
  localparam int LONG_N  = 16;
  localparam int SHORT_N = 4;
  localparam int CNT_W   = $clog2(LONG_N + 2);
  localparam int BUF_W   = LONG_N * 8;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_N + 1);
  localparam logic [7:0] FLAG_MASK = 8'hC4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;

  state_t           st;
  logic [ARG_W-1:0] arg_q;
  logic [BUF_W-1:0] shadow, shadow_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [7:0]       flags_q;

  wire start   = (st == S_IDLE) && cmd_wr && wdata[10] && !wdata[9];
  wire beat    = (st == S_RSP) && rsp_valid;
  wire carries = beat && !rsp_err && !rsp_nodata;
  wire fin     = beat && (rsp_last || rsp_err);
  wire want    = cmd_q[6];
  wire len_ok  = (cnt_nx == CNT_W'(LONG_N)) || ((cnt_nx == CNT_W'(SHORT_N)) && !cmd_q[7]);
  wire set_tmo  = fin && (rsp_err || (want && !len_ok));
  wire set_rsp  = fin && !rsp_err && want && len_ok;
  wire set_sent = fin && !rsp_err && !want;
  wire [7:0] set8 = {set_sent, set_rsp, 3'b000, set_tmo, 2'b00};

  assign busy      = (st != S_IDLE);
  assign req_valid = (st == S_REQ);
  assign req_index = cmd_q[5:0];
  assign req_arg   = arg_q;
  assign st_flags  = flags_q;
  assign cnt_nx    = (carries && cnt != CNT_SAT) ? cnt + 1'b1 : cnt;

  always_comb begin
    shadow_nx = shadow;
    for (int k = 0; k < LONG_N; k++)
      if (carries && cnt == CNT_W'(k))
        shadow_nx[BUF_W-1-8*k -: 8] = rsp_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      arg_q   <= '0;
      shadow  <= '0;
      cnt     <= '0;
      flags_q <= '0;
      resp0   <= '0;
      resp1   <= '0;
      resp2   <= '0;
      resp3   <= '0;
    end else begin
      flags_q <= ((flags_q & ~flag_clr) | set8) & FLAG_MASK;
      case (st)
        S_IDLE: begin
          if (arg_wr) arg_q <= wdata;
          if (cmd_wr) cmd_q <= {wdata[10] & ~wdata[9], wdata[9:0]};
          if (start) begin
            st  <= S_REQ;
            cnt <= '0;
          end
        end
        S_REQ: if (req_ready) st <= S_RSP;
        S_RSP: begin
          cnt    <= cnt_nx;
          shadow <= shadow_nx;
          if (fin) begin
            st       <= S_IDLE;
            cmd_q[10] <= 1'b0;
          end
          if (set_rsp) begin
            resp0 <= shadow_nx[BUF_W-1 -: 32];
            if (cnt_nx == CNT_W'(LONG_N)) begin
              resp1 <= shadow_nx[BUF_W-33 -: 32];
              resp2 <= shadow_nx[BUF_W-65 -: 32];
              resp3 <= {shadow_nx[BUF_W-97 -: 31], 1'b0};
            end else begin
              resp1 <= '0;
              resp2 <= '0;
              resp3 <= '0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

  assert_pending_noissue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && wdata[9]) |=> !busy);

  assert_enable_tracks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy == cmd_q[10]);

  assert_busy_blocks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q[9:0]));

  assert_long_lsb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp3[0] == 1'b0);

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && flag_clr == 8'h00) |=> $stable(st_flags));
endmodule

// File: tb/card_cmd_unit_bench.sv
module card_cmd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arg_wr = 1'b0, cmd_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  flag_clr = '0;
  logic [10:0] cmd_q;
  logic        busy;
  logic [7:0]  st_flags;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic        req_valid, req_ready = 1'b0;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic        rsp_valid = 1'b0, rsp_nodata = 1'b0, rsp_last = 1'b0, rsp_err = 1'b0;
  logic [7:0]  rsp_byte = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  card_cmd_unit u_card_cmd_unit (
    .clk, .rst_n, .arg_wr, .cmd_wr, .wdata, .flag_clr, .cmd_q, .busy, .st_flags,
    .resp0, .resp1, .resp2, .resp3, .req_valid, .req_ready, .req_index, .req_arg,
    .rsp_valid, .rsp_byte, .rsp_nodata, .rsp_last, .rsp_err);

  // Behavioural reference model
  logic [10:0] m_cmd;
  logic [31:0] m_arg;
  logic [31:0] m_r [4];
  logic [7:0]  m_fl;
  int          m_ph;
  logic [7:0]  m_q [$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cmd = '0; m_arg = '0; m_fl = '0; m_ph = 0; m_q.delete();
      for (int i = 0; i < 4; i++) m_r[i] = '0;
    end else begin
      logic [7:0] setv;
      setv = '0;
      if (m_ph == 0) begin
        if (arg_wr) m_arg = wdata;
        if (cmd_wr) begin
          m_cmd = wdata[10:0];
          if (wdata[9]) m_cmd[10] = 1'b0;
          if (wdata[10] && !wdata[9]) m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (req_ready) begin m_ph = 2; m_q.delete(); end
      end else if (rsp_valid) begin
        if (!rsp_err && !rsp_nodata) m_q.push_back(rsp_byte);
        if (rsp_last || rsp_err) begin
          int n;
          n = m_q.size();
          if (rsp_err) setv[2] = 1'b1;
          else if (m_cmd[6]) begin
            if (n == 16 || (n == 4 && !m_cmd[7])) begin
              setv[6] = 1'b1;
              for (int w = 0; w < 4; w++)
                m_r[w] = (n == 16) ? {m_q[4*w], m_q[4*w+1], m_q[4*w+2], m_q[4*w+3]}
                                   : ((w == 0) ? {m_q[0], m_q[1], m_q[2], m_q[3]} : 32'h0);
              m_r[3][0] = 1'b0;
            end else setv[2] = 1'b1;
          end else setv[7] = 1'b1;
          m_cmd[10] = 1'b0;
          m_ph = 0;
        end
      end
      m_fl = (m_fl & ~flag_clr) | setv;
      m_fl = m_fl & 8'hC4;
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= 2 && !done) begin
      chk("R2 busy", busy, m_ph != 0);
      chk("R2 req_valid", req_valid, m_ph == 1);
      if (m_ph == 1) begin
        chk("R2 req_index", req_index, m_cmd[5:0]);
        chk("R2 req_arg", req_arg, m_arg);
      end
      chk("R4 cmd_q", cmd_q, m_cmd);
      chk("R5 resp0", resp0, m_r[0]);
      chk("R5 resp1", resp1, m_r[1]);
      chk("R5 resp2", resp2, m_r[2]);
      chk("R5 resp3", resp3, m_r[3]);
      chk("R11 flags", st_flags, m_fl);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic host_cmd(logic [31:0] v);
    cmd_wr = 1; wdata = v; @(negedge clk); cmd_wr = 0;
  endtask
  task automatic host_arg(logic [31:0] v);
    arg_wr = 1; wdata = v; @(negedge clk); arg_wr = 0;
  endtask
  task automatic grant(int d);
    while (!req_valid) @(negedge clk);
    repeat (d) @(negedge clk);
    req_ready = 1; @(negedge clk); req_ready = 0;
  endtask
  task automatic beat(logic [7:0] b, logic last, logic nd, logic er);
    rsp_valid = 1; rsp_byte = b; rsp_last = last; rsp_nodata = nd; rsp_err = er;
    @(negedge clk);
    rsp_valid = 0; rsp_last = 0; rsp_nodata = 0; rsp_err = 0;
  endtask
  task automatic send(logic [7:0] base, int n, bit last);
    for (int i = 0; i < n; i++) begin
      beat(base + 8'(i), last && (i == n - 1), 0, 0);
      if (i % 3 == 1) @(negedge clk);
    end
  endtask
  task automatic clear_all();
    flag_clr = 8'hFF; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", st_flags, 0);
    chk("R1 busy", busy, 0);
    chk("R1 cmd_q", cmd_q, 0);
    chk("R1 resp0", resp0, 0);

    // R5/R6 short response
    host_arg(32'hCAFE0001);
    host_cmd(32'h451);
    grant(2);
    send(8'hA0, 4, 1);
    chk("R5 resp0 packing", resp0, 32'hA0A1A2A3);
    chk("R6 resp1 zero", resp1, 0);
    chk("R6 flag bit6", st_flags, 8'h40);
    flag_clr = 8'h40; @(negedge clk); flag_clr = 0;
    chk("R11 clear", st_flags, 0);

    // R7 long response
    host_cmd(32'h4C2);
    grant(0);
    send(8'h10, 16, 1);
    chk("R7 resp0", resp0, 32'h10111213);
    chk("R7 resp3 lsb", resp3, 32'h1C1D1E1E);
    chk("R7 flag", st_flags, 8'h40);
    clear_all();

    // R8 four bytes while long requested
    host_cmd(32'h4C3);
    grant(1);
    send(8'h50, 4, 1);
    chk("R8 short vs long flag", st_flags, 8'h04);
    chk("R8 resp kept", resp0, 32'h10111213);
    clear_all();

    // R8 zero bytes
    host_cmd(32'h444);
    grant(0);
    beat(8'h00, 1, 1, 0);
    chk("R8 empty reply", st_flags, 8'h04);
    clear_all();

    // R8 seven bytes, ended by a data-free terminator
    host_cmd(32'h445);
    grant(0);
    send(8'h60, 7, 0);
    beat(8'h00, 1, 1, 0);
    chk("R8 odd length", st_flags, 8'h04);
    chk("R8 resp3 kept", resp3, 32'h1C1D1E1E);
    clear_all();

    // R7 sixteen bytes without long bit
    host_cmd(32'h446);
    grant(0);
    send(8'h80, 16, 1);
    chk("R7 long w/o bit7", resp1, 32'h84858687);
    chk("R7 long w/o bit7 flag", st_flags, 8'h40);
    clear_all();

    // R9 no response expected
    host_cmd(32'h405);
    grant(0);
    send(8'hE0, 3, 1);
    chk("R9 sent flag", st_flags, 8'h80);
    chk("R9 resp kept", resp0, 32'h80818283);
    clear_all();

    // R10 error beat
    host_cmd(32'h447);
    grant(0);
    send(8'h30, 2, 0);
    beat(8'h00, 0, 0, 1);
    chk("R10 error flag", st_flags, 8'h04);
    chk("R10 resp kept", resp0, 32'h80818283);
    clear_all();

    // R3 pending bit
    host_cmd(32'h640);
    repeat (3) @(negedge clk);
    chk("R3 no request", busy, 0);
    chk("R3 stored", cmd_q, 11'h240);

    // R12 interrupt mode has no effect
    host_cmd(32'h541);
    grant(0);
    send(8'h44, 4, 1);
    chk("R12 flag", st_flags, 8'h40);
    chk("R12 resp0", resp0, 32'h44454647);
    clear_all();

    // R4 writes ignored while busy
    host_arg(32'h12345678);
    host_cmd(32'h451);
    grant(0);
    host_cmd(32'h7C3);
    host_arg(32'h55555555);
    chk("R4 cmd held", cmd_q, 11'h451);
    send(8'h90, 4, 1);
    chk("R4 enable cleared", cmd_q, 11'h051);
    host_cmd(32'h451);
    while (!req_valid) @(negedge clk);
    chk("R4 arg held", req_arg, 32'h12345678);
    grant(0);
    send(8'h91, 4, 1);
    clear_all();

    // R13 stray beats while idle and while waiting for grant
    beat(8'h99, 1, 0, 0);
    chk("R13 idle beat", st_flags, 0);
    chk("R13 idle resp", resp0, 32'h91929394);
    host_cmd(32'h452);
    beat(8'h77, 1, 0, 0);
    chk("R13 waiting beat", busy, 1);
    grant(1);
    send(8'hB0, 4, 1);
    chk("R13 reply after stray", resp0, 32'hB0B1B2B3);
    clear_all();

    // R11 set wins over clear in the same cycle
    host_cmd(32'h453);
    grant(0);
    send(8'hC0, 3, 0);
    flag_clr = 8'hFF;
    beat(8'hC3, 1, 0, 0);
    flag_clr = 0;
    chk("R11 set beats clear", st_flags, 8'h40);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule